// File: doc/BRIEF.md
# GPIO Interrupt Sensitivity Controller

This block watches a bank of general-purpose input pins and turns activity on them into interrupt requests. Every pin has its own sensitivity setting: it can fire on a rising transition, a falling transition, either transition, while the pin is high, or while it is low. Pins enter through a two-stage synchroniser. Transitions are found by comparing the current synchronised sample with the one taken a cycle earlier.

Each pin has one raw status bit. In the transition modes this bit latches and holds until software clears it by writing a one to it. In the level modes it tracks the synchronised pin, so it cannot be cleared while the level is still active. A per-pin enable register masks the raw status to give the masked status. The single interrupt output is the OR of all masked bits. Software reads and writes the control state through a plain register port: a valid strobe, a write flag, an address and write data. A read returns its data one cycle after the request.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After synchronous reset, the enable register, raw status and masked status read 0, every pin's mode reads 7 (disabled), and `irq_o` is 0.
- R2: A pin change is first reflected in raw status, and in `irq_o`, after the third rising clock edge that follows it. The path is two synchroniser stages plus the status register.
- R3: In mode 0, a 0-to-1 transition sets the pin's raw bit. A 1-to-0 transition neither sets nor clears it.
- R4: In mode 1, a 1-to-0 transition sets the pin's raw bit. A 0-to-1 transition does not set it.
- R5: In mode 2, both transitions set the pin's raw bit.
- R6: In mode 3 the raw bit equals the synchronised pin level, and in mode 4 it equals the inverted level. Writing 1 to a level-mode raw bit while the level is active leaves it set.
- R7: In modes 0 to 2, a set raw bit stays set until software writes 1 to that bit at address 1. Bits written as 0 are left unchanged.
- R8: Mode codes 5, 6 and 7 disable a pin, and its raw bit stays 0 whatever the pin does.
- R9: Any write to a pin's mode register clears that pin's raw bit at the same clock edge.
- R10: Address 1 reads raw status and address 2 reads masked status. Masked status is raw status ANDed with the enable register at address 0, and bit i belongs to pin i.
- R11: `irq_o` is high exactly when at least one masked status bit is set.
- R12: A read request produces `rsp_valid` one cycle later with the data. Pin i's mode is read and written at address 8+i in bits [2:0], and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PINS | Asynchronous general-purpose inputs |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | DATA_W | Read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench counts clock edges from a pin change to the interrupt output. A design with one synchroniser stage too few or too many would assert early or late. In each transition mode it drives the opposite transition, which a mode decoder with swapped codes would latch. It also writes zero bits to the clear register, which a design that clears by writing the register would get wrong. A level-mode bit is written with 1 while its level is active, to catch a design that lets the clear stick. Disabled codes, rewriting a mode to its current value, and masking a set raw bit are each checked at the status registers and at `irq_o`. These catch a design that never disables, a design that only clears on a changed value, and a design that routes raw status to the interrupt.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Sensitivity codes, 3 bits per pin; 5..7 disable the pin
    localparam int          SENSE_W    = 3;
    localparam logic [2:0]  SENSE_RISE = 3'd0;
    localparam logic [2:0]  SENSE_FALL = 3'd1;
    localparam logic [2:0]  SENSE_BOTH = 3'd2;
    localparam logic [2:0]  SENSE_HIGH = 3'd3;
    localparam logic [2:0]  SENSE_LOW  = 3'd4;
    localparam logic [2:0]  SENSE_OFF  = 3'd7;

    // Register addresses
    localparam int REG_ENABLE    = 0;
    localparam int REG_RAW       = 1;
    localparam int REG_MASKED    = 2;
    localparam int REG_MODE_BASE = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_RAW,
        SEL_MASKED,
        SEL_MODE
    } reg_sel_e;

    // Per-pin control bundle from the register port to a detector
    typedef struct packed {
        logic             mode_wr;
        logic             w1c;
        logic [SENSE_W-1:0] mode;
    } pin_ctl_t;

    function automatic logic is_edge_mode(input logic [SENSE_W-1:0] m);
        return (m == SENSE_RISE) || (m == SENSE_FALL) || (m == SENSE_BOTH);
    endfunction

    function automatic logic is_level_mode(input logic [SENSE_W-1:0] m);
        return (m == SENSE_HIGH) || (m == SENSE_LOW);
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int NUM_PINS = 8,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] async_i,
    output logic [NUM_PINS-1:0] sync_o
);
    logic [STAGES-1:0][NUM_PINS-1:0] chain_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= '0;
                else     chain_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[s] <= '0;
                else     chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     smp_i,
    input  pin_ctl_t ctl_i,
    output logic     raw_o
);
    logic prev_q;
    logic raw_q;
    logic rise, fall, hit;
    logic raw_d;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= smp_i;
    end

    always_comb begin
        rise = smp_i & ~prev_q;
        fall = ~smp_i & prev_q;
        case (ctl_i.mode)
            SENSE_RISE: hit = rise;
            SENSE_FALL: hit = fall;
            SENSE_BOTH: hit = rise | fall;
            default:    hit = 1'b0;
        endcase
    end

    always_comb begin
        if (ctl_i.mode_wr) begin
            raw_d = 1'b0;
        end else if (is_edge_mode(ctl_i.mode)) begin
            raw_d = (raw_q & ~ctl_i.w1c) | hit;
        end else if (ctl_i.mode == SENSE_HIGH) begin
            raw_d = smp_i;
        end else if (ctl_i.mode == SENSE_LOW) begin
            raw_d = ~smp_i;
        end else begin
            raw_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) raw_q <= 1'b0;
        else     raw_q <= raw_d;
    end

    assign raw_o = raw_q;

    // R9: a mode write empties the latch at that edge
    assert_mode_clear_R9: assert property (@(posedge clk) disable iff (rst)
        ctl_i.mode_wr |=> !raw_q);

    // R8: disabled codes never raise status
    assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (!is_edge_mode(ctl_i.mode) && !is_level_mode(ctl_i.mode)) |=> !raw_q);

    // R7: latched transition status holds without a clear
    assert_edge_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (is_edge_mode(ctl_i.mode) && raw_q && !ctl_i.w1c && !ctl_i.mode_wr) |=> raw_q);

    // R6: high-level status tracks the synchronised pin
    assert_level_follow_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.mode == SENSE_HIGH && !ctl_i.mode_wr) |=> (raw_q == $past(smp_i)));

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [NUM_PINS-1:0]      raw_i,
    input  logic [NUM_PINS-1:0]      masked_i,
    output logic                     rsp_valid,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic [NUM_PINS-1:0]      enable_o,
    output pin_ctl_t [NUM_PINS-1:0]  ctl_o
);
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [NUM_PINS-1:0]              enable_q;
    logic [NUM_PINS-1:0][SENSE_W-1:0] mode_q;
    reg_sel_e                         sel;
    logic [IDX_W-1:0]                 idx;
    logic                             wr, rd;
    logic [DATA_W-1:0]                rdata_d;
    logic                             unused_hi;

    assign unused_hi = ^req_wdata[DATA_W-1:NUM_PINS];
    assign wr = req_valid & req_write;
    assign rd = req_valid & ~req_write;

    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        if (req_addr == ADDR_W'(REG_ENABLE)) begin
            sel = SEL_ENABLE;
        end else if (req_addr == ADDR_W'(REG_RAW)) begin
            sel = SEL_RAW;
        end else if (req_addr == ADDR_W'(REG_MASKED)) begin
            sel = SEL_MASKED;
        end else if ((int'(req_addr) >= REG_MODE_BASE) &&
                     (int'(req_addr) - REG_MODE_BASE < NUM_PINS)) begin
            sel = SEL_MODE;
            idx = IDX_W'(int'(req_addr) - REG_MODE_BASE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            for (int i = 0; i < NUM_PINS; i++) mode_q[i] <= SENSE_OFF;
        end else if (wr) begin
            if (sel == SEL_ENABLE) enable_q <= req_wdata[NUM_PINS-1:0];
            if (sel == SEL_MODE)   mode_q[idx] <= req_wdata[SENSE_W-1:0];
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_ctl
        assign ctl_o[p].mode    = mode_q[p];
        assign ctl_o[p].mode_wr = wr && (sel == SEL_MODE) && (idx == IDX_W'(p));
        assign ctl_o[p].w1c     = wr && (sel == SEL_RAW) && req_wdata[p];
    end

    always_comb begin
        case (sel)
            SEL_ENABLE: rdata_d = {{(DATA_W-NUM_PINS){1'b0}}, enable_q};
            SEL_RAW:    rdata_d = {{(DATA_W-NUM_PINS){1'b0}}, raw_i};
            SEL_MASKED: rdata_d = {{(DATA_W-NUM_PINS){1'b0}}, masked_i};
            SEL_MODE:   rdata_d = {{(DATA_W-SENSE_W){1'b0}}, mode_q[idx]};
            default:    rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd;
            rsp_rdata <= rd ? rdata_d : '0;
        end
    end

    assign enable_o = enable_q;

    // R12: every read is answered on the following cycle
    assert_read_resp_R12: assert property (@(posedge clk) disable iff (rst)
        rd |=> rsp_valid);

    assert_no_stray_resp_R12: assert property (@(posedge clk) disable iff (rst)
        !rd |=> !rsp_valid);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                irq_o
);
    logic [NUM_PINS-1:0]     smp;
    logic [NUM_PINS-1:0]     raw;
    logic [NUM_PINS-1:0]     masked;
    logic [NUM_PINS-1:0]     enable;
    pin_ctl_t [NUM_PINS-1:0] ctl;

    gpio_irq_sync #(
        .NUM_PINS (NUM_PINS),
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pins_i),
        .sync_o  (smp)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_irq_detect u_det (
            .clk   (clk),
            .rst   (rst),
            .smp_i (smp[p]),
            .ctl_i (ctl[p]),
            .raw_o (raw[p])
        );
    end

    gpio_irq_regs #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .raw_i     (raw),
        .masked_i  (masked),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .enable_o  (enable),
        .ctl_o     (ctl)
    );

    assign masked = raw & enable;
    assign irq_o  = |masked;

    // R11: with every pin masked the request line stays low
    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |-> !irq_o);

    // R10: a pin with no raw status never shows masked status
    assert_masked_needs_raw_R10: assert property (@(posedge clk) disable iff (rst)
        (raw == '0) |-> !irq_o);

endmodule

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
    localparam int NP = 8;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] pins;
    logic          req_valid;
    logic          req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          irq;

    int vectors = 0;
    int misses  = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #5 clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(NP), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .pins_i(pins),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq)
    );

    // Monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            vectors++;
            if (exp_q.size() == 0) begin
                misses++;
                $display("FAIL R12 unexpected response: actual %h expected none", rsp_rdata);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_rdata !== e) begin
                    misses++;
                    $display("FAIL %s: actual %h expected %h", t, rsp_rdata, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_expect(input int a, input logic [DW-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic irq_expect(input logic e, input string t);
        vectors++;
        if (irq !== e) begin
            misses++;
            $display("FAIL %s irq: actual %b expected %b", t, irq, e);
        end
    endtask

    task automatic set_pin(input int p, input logic v);
        @(negedge clk);
        pins[p] = v;
    endtask

    initial begin
        #2000000;
        misses++;
        $display("FAIL watchdog expired: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        rst = 1'b1; pins = '0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        idle(4);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        irq_expect(1'b0, "R1");
        rd_expect(0, 32'h0, "R1 enable");
        rd_expect(1, 32'h0, "R1 raw");
        rd_expect(2, 32'h0, "R1 masked");
        rd_expect(8, 32'h7, "R1 mode pin0");
        rd_expect(3, 32'h0, "R12 unmapped");

        wr(0, 32'hFF);
        rd_expect(0, 32'hFF, "R12 enable readback");

        // R2 / R3: rising on pin 0, exact latency
        wr(8, 32'h0);
        idle(4);
        set_pin(0, 1'b1);
        @(negedge clk); @(negedge clk);
        irq_expect(1'b0, "R2 after two edges");
        @(negedge clk);
        irq_expect(1'b1, "R2 after three edges");
        idle(2);
        rd_expect(1, 32'h01, "R3 rise raw");
        rd_expect(2, 32'h01, "R10 masked");
        set_pin(0, 1'b0);
        idle(5);
        rd_expect(1, 32'h01, "R3 fall keeps raw");
        wr(1, 32'h01);
        irq_expect(1'b0, "R7 cleared");
        rd_expect(1, 32'h00, "R7 w1c clears");

        // R4: falling on pin 1
        wr(9, 32'h1);
        set_pin(1, 1'b1);
        idle(5);
        rd_expect(1, 32'h00, "R4 rise ignored");
        set_pin(1, 1'b0);
        idle(5);
        rd_expect(1, 32'h02, "R4 fall latched");
        wr(1, 32'h00);
        rd_expect(1, 32'h02, "R7 zero bits no effect");
        wr(1, 32'h02);
        rd_expect(1, 32'h00, "R7 clear pin1");

        // R5: both edges on pin 2
        wr(10, 32'h2);
        set_pin(2, 1'b1);
        idle(5);
        rd_expect(1, 32'h04, "R5 rise");
        wr(1, 32'h04);
        rd_expect(1, 32'h00, "R5 cleared");
        set_pin(2, 1'b0);
        idle(5);
        rd_expect(1, 32'h04, "R5 fall");
        wr(1, 32'h04);

        // R6: high level pin 3, low level pin 4
        wr(11, 32'h3);
        set_pin(3, 1'b1);
        idle(5);
        rd_expect(1, 32'h08, "R6 high level");
        wr(1, 32'h08);
        idle(2);
        rd_expect(1, 32'h08, "R6 clear ignored while high");
        set_pin(3, 1'b0);
        idle(5);
        rd_expect(1, 32'h00, "R6 high released");
        wr(12, 32'h4);
        idle(3);
        rd_expect(1, 32'h10, "R6 low level");
        set_pin(4, 1'b1);
        idle(5);
        rd_expect(1, 32'h00, "R6 low released");

        // R8: disabled codes
        wr(13, 32'h5);
        wr(14, 32'h7);
        set_pin(5, 1'b1); set_pin(6, 1'b1);
        idle(5);
        set_pin(5, 1'b0); set_pin(6, 1'b0);
        idle(5);
        rd_expect(1, 32'h00, "R8 disabled pins");
        irq_expect(1'b0, "R8");
        rd_expect(13, 32'h5, "R12 mode readback");

        // R9: rewriting mode clears latched bit
        set_pin(0, 1'b1);
        idle(5);
        rd_expect(1, 32'h01, "R9 set before rewrite");
        wr(8, 32'h0);
        idle(2);
        rd_expect(1, 32'h00, "R9 cleared by mode write");
        irq_expect(1'b0, "R9");

        // R10 / R11: masking
        wr(15, 32'h0);
        set_pin(7, 1'b1);
        idle(5);
        wr(0, 32'h7F);
        rd_expect(1, 32'h80, "R10 raw unmasked view");
        rd_expect(2, 32'h00, "R10 masked hides pin7");
        irq_expect(1'b0, "R11 masked off");
        wr(0, 32'hFF);
        rd_expect(2, 32'h80, "R10 masked shows pin7");
        irq_expect(1'b1, "R11 asserted");

        idle(4);
        if (exp_q.size() != 0) begin
            misses++;
            $display("FAIL R12 missing responses: actual %0d left expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule